// File: doc/BRIEF.md
# MOESI Snooping Coherence Line Controller

This block tracks the coherence state of one cache line in a private cache attached to a shared snooping bus. It uses five states: Invalid, Shared, Exclusive, Owned and Modified. It takes the local processor's read and write requests, the fill response for a miss, and the bus reads and invalidates that other caches issue. From these it produces the next state and the bus actions the cache must take: announce a read miss, broadcast an invalidate, supply the line's data, or request a writeback when the line is evicted.

The Owned state lets a dirty line stay shared without an update to memory, because the owner answers snooped reads in place of memory. The Exclusive state lets a clean line that no other cache holds be written with no bus traffic. Bus actions are combinational outputs in the cycle of the event that causes them. The state changes at the next rising clock edge. At most one event is handled per cycle, chosen by a fixed priority. The data arrays, tag match, bus arbitration and memory controller lie outside this block.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `line_state` is Invalid, no read miss is outstanding, and all four bus action outputs are 0. The state codes are Invalid=0, Shared=1, Exclusive=2, Owned=3 and Modified=4.
- R2: A local read in Invalid with no miss outstanding raises `bus_rd_miss` for that cycle only, and the line stays Invalid. A later fill with `fill_shared`=0 moves the line to Exclusive. A later fill with `fill_shared`=1 moves it to Shared.
- R3: A local write in Invalid with no miss outstanding raises both `bus_rd_miss` and `bus_inv` in that cycle. The fill that follows moves the line to Modified whatever the value of `fill_shared`.
- R4: A local write in Exclusive or Modified leaves the line in Modified and raises no bus output.
- R5: A local write in Shared or Owned raises `bus_inv` in that cycle and moves the line to Modified.
- R6: A snooped read in Modified raises `supply_data` and moves the line to Owned. In Owned it raises `supply_data` and the line stays Owned. In Exclusive the line moves to Shared with no supply. In Shared the line stays Shared with no supply.
- R7: A snooped invalidate moves any valid state to Invalid and raises no output.
- R8: An eviction in Modified or Owned raises `writeback_req` and moves the line to Invalid. An eviction in Exclusive or Shared moves the line to Invalid with no writeback.
- R9: When the line is valid, a snooped invalidate takes precedence over a snooped read. A snooped read takes precedence over an eviction and over local requests, and events that lose in a cycle have no effect. When the line is Invalid, snoops have no effect. The full priority order is: snoop invalidate, snoop read, fill, evict, local write, local read.
- R10: A local read in Exclusive, Shared, Owned or Modified raises no output and leaves the state unchanged.
- R11: A fill with no miss outstanding is ignored. While a miss is outstanding, further local requests raise no output and do not change the kind of miss awaited. An eviction in Invalid raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_rd | input | 1 | Local processor read of the line |
| cpu_wr | input | 1 | Local processor write of the line |
| fill_valid | input | 1 | Fill response for an outstanding miss |
| fill_shared | input | 1 | With the fill: another cache holds a copy |
| snp_rd | input | 1 | Snooped read from another cache |
| snp_inv | input | 1 | Snooped invalidate from another cache |
| evict | input | 1 | The line is being replaced |
| line_state | output | 3 | Current coherence state code |
| bus_rd_miss | output | 1 | Announce a read miss on the bus this cycle |
| bus_inv | output | 1 | Broadcast an invalidate this cycle |
| supply_data | output | 1 | Drive the line's data onto the bus for a snooped read |
| writeback_req | output | 1 | Write the dirty line back on eviction |

## Verification
The block has no parameters, so the bench builds it exactly as it will be used. Seven starting conditions are set up through the ports: the five settled states, a read miss outstanding, and a write miss outstanding. Each starting condition is driven with all 128 combinations of the seven event inputs. This covers every priority collision, every ignored fill and every repeated request under a pending miss, and each result is compared with a model written from the requirements.

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_rd,
  input  logic       cpu_wr,
  input  logic       fill_valid,
  input  logic       fill_shared,
  input  logic       snp_rd,
  input  logic       snp_inv,
  input  logic       evict,
  output logic [2:0] line_state,
  output logic       bus_rd_miss,
  output logic       bus_inv,
  output logic       supply_data,
  output logic       writeback_req
);
  localparam logic [2:0] ST_I = 3'd0;
  localparam logic [2:0] ST_S = 3'd1;
  localparam logic [2:0] ST_E = 3'd2;
  localparam logic [2:0] ST_O = 3'd3;
  localparam logic [2:0] ST_M = 3'd4;

  localparam logic [1:0] PEND_NONE = 2'd0;
  localparam logic [1:0] PEND_RD   = 2'd1;
  localparam logic [1:0] PEND_WR   = 2'd2;

  logic [2:0] st, st_nx;
  logic [1:0] pend, pend_nx;
  logic       valid, dirty;

  assign valid      = (st != ST_I);
  assign dirty      = (st == ST_M) || (st == ST_O);
  assign line_state = st;

  always_comb begin
    st_nx         = st;
    pend_nx       = pend;
    bus_rd_miss   = 1'b0;
    bus_inv       = 1'b0;
    supply_data   = 1'b0;
    writeback_req = 1'b0;
    if (valid && snp_inv) begin
      st_nx = ST_I;
    end else if (valid && snp_rd) begin
      supply_data = dirty;
      if (st == ST_M) st_nx = ST_O;
      if (st == ST_E) st_nx = ST_S;
    end else if (pend != PEND_NONE && fill_valid) begin
      st_nx   = (pend == PEND_WR) ? ST_M : (fill_shared ? ST_S : ST_E);
      pend_nx = PEND_NONE;
    end else if (evict) begin
      writeback_req = dirty;
      st_nx         = ST_I;
    end else if (cpu_wr) begin
      case (st)
        ST_I: if (pend == PEND_NONE) begin
          bus_rd_miss = 1'b1;
          bus_inv     = 1'b1;
          pend_nx     = PEND_WR;
        end
        ST_S, ST_O: begin
          bus_inv = 1'b1;
          st_nx   = ST_M;
        end
        default: st_nx = ST_M;
      endcase
    end else if (cpu_rd) begin
      if (st == ST_I && pend == PEND_NONE) begin
        bus_rd_miss = 1'b1;
        pend_nx     = PEND_RD;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_I;
      pend <= PEND_NONE;
    end else begin
      st   <= st_nx;
      pend <= pend_nx;
    end
  end

  assert_legal_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    line_state <= ST_M);

  assert_supply_leaves_owned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    supply_data |=> line_state == ST_O);

  assert_writeback_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    writeback_req |=> line_state == ST_I);

  assert_inv_enters_m_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_inv && line_state != ST_I) |=> line_state == ST_M);

  assert_snoop_inv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_inv && line_state != ST_I) |=> line_state == ST_I);

  assert_silent_upgrade_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == ST_E && cpu_wr && !snp_rd && !snp_inv && !evict)
      |-> (!bus_inv && !bus_rd_miss));

  assert_miss_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_miss |=> !bus_rd_miss);
endmodule

// File: tb/moesi_line_ctrl_tb.sv
module moesi_line_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_rd = 0, cpu_wr = 0, fill_valid = 0, fill_shared = 0;
  logic snp_rd = 0, snp_inv = 0, evict = 0;
  logic [2:0] line_state;
  logic bus_rd_miss, bus_inv, supply_data, writeback_req;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  moesi_line_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .fill_valid(fill_valid), .fill_shared(fill_shared), .snp_rd(snp_rd),
    .snp_inv(snp_inv), .evict(evict), .line_state(line_state),
    .bus_rd_miss(bus_rd_miss), .bus_inv(bus_inv), .supply_data(supply_data),
    .writeback_req(writeback_req)
  );

  // v bits: 0 cpu_rd, 1 cpu_wr, 2 fill_valid, 3 fill_shared, 4 snp_rd, 5 snp_inv, 6 evict
  task automatic drive(input logic [6:0] v);
    cpu_rd = v[0]; cpu_wr = v[1]; fill_valid = v[2]; fill_shared = v[3];
    snp_rd = v[4]; snp_inv = v[5]; evict = v[6];
  endtask

  task automatic cyc(input logic [6:0] v);
    @(negedge clk);
    drive(v);
    @(posedge clk);
    #1;
    drive(7'd0);
  endtask

  // Expected behaviour from the requirements; pend: 0 none, 1 read, 2 write.
  task automatic model(input int s, input int p, input logic [6:0] v,
                       output int ns, output logic [3:0] outs, output string tag);
    bit rd = v[0], wr = v[1], fv = v[2], fs = v[3], sr = v[4], si = v[5], ev = v[6];
    ns = s; outs = 4'b0; tag = "R11";
    if (s != 0 && si) begin ns = 0; tag = "R7"; end
    else if (s != 0 && sr) begin
      tag = "R6";
      if (s == 4) begin ns = 3; outs[2] = 1; end
      else if (s == 3) outs[2] = 1;
      else if (s == 2) ns = 1;
    end
    else if (p != 0 && fv) begin
      if (p == 2) begin ns = 4; tag = "R3"; end
      else begin ns = fs ? 1 : 2; tag = "R2"; end
    end
    else if (ev) begin
      tag = (s == 0) ? "R11" : "R8";
      if (s == 3 || s == 4) outs[3] = 1;
      ns = 0;
    end
    else if (wr) begin
      if (s == 0) begin
        if (p == 0) begin outs[0] = 1; outs[1] = 1; tag = "R3"; end
      end else if (s == 1 || s == 3) begin outs[1] = 1; ns = 4; tag = "R5"; end
      else begin ns = 4; tag = "R4"; end
    end
    else if (rd) begin
      if (s == 0) begin
        if (p == 0) begin outs[0] = 1; tag = "R2"; end
      end else tag = "R10";
    end
    if ((si || sr) && s != 0 && (v & 7'b1001111) != 0) tag = {tag, "/R9"};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    drive(7'd0);
    @(posedge clk); @(posedge clk); #1;
    rst_n = 1;
  endtask

  task automatic setup(input int cfg);
    case (cfg)
      1: begin cyc(7'b0000001); cyc(7'b0001100); end
      2: begin cyc(7'b0000001); cyc(7'b0000100); end
      3: begin cyc(7'b0000010); cyc(7'b0000100); cyc(7'b0010000); end
      4: begin cyc(7'b0000010); cyc(7'b0000100); end
      5: cyc(7'b0000001);
      6: cyc(7'b0000010);
      default: ;
    endcase
  endtask

  initial begin
    int ns;
    logic [3:0] eo, ao;
    string tag;
    do_reset();
    n_tests++;
    if (line_state !== 3'd0 || bus_rd_miss || bus_inv || supply_data || writeback_req) begin
      n_fail++;
      $display("FAIL R1 reset: state=%0d outs=%b%b%b%b expected state=0 outs=0000",
               line_state, writeback_req, supply_data, bus_inv, bus_rd_miss);
    end
    for (int cfg = 0; cfg < 7; cfg++) begin
      for (int vi = 0; vi < 128; vi++) begin
        int s0, p0;
        logic [6:0] v = 7'(vi);
        s0 = (cfg <= 4) ? ((cfg == 1) ? 1 : (cfg == 2) ? 2 : (cfg == 3) ? 3 : (cfg == 4) ? 4 : 0) : 0;
        p0 = (cfg == 5) ? 1 : (cfg == 6) ? 2 : 0;
        do_reset();
        setup(cfg);
        model(s0, p0, v, ns, eo, tag);
        @(negedge clk);
        n_tests++;
        if (line_state !== 3'(s0)) begin
          n_fail++;
          $display("FAIL R1 setup cfg=%0d: state=%0d expected=%0d", cfg, line_state, s0);
        end
        drive(v);
        #1;
        ao = {writeback_req, supply_data, bus_inv, bus_rd_miss};
        n_tests++;
        if (ao !== eo) begin
          n_fail++;
          $display("FAIL %s cfg=%0d in=%b: outs(wb,sup,inv,miss)=%b expected=%b",
                   tag, cfg, v, ao, eo);
        end
        @(posedge clk);
        #1;
        drive(7'd0);
        n_tests++;
        if (line_state !== 3'(ns)) begin
          n_fail++;
          $display("FAIL %s cfg=%0d in=%b: next state=%0d expected=%0d",
                   tag, cfg, v, line_state, ns);
        end
      end
    end
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule